// File: doc/BRIEF.md
# Clock Root Configuration Register Bank

This block holds the settings of one clock root generator behind a small word-addressed register port. Software programs a source-select code, a pre-divider, a counter mode and three fractional-counter values (M, N, D) into shadow registers. None of those writes reaches the generator until software sets the update request bit in the command register. The request is then carried across a fixed synchronisation delay. At the end of that delay, every active output takes the shadow contents in the same clock edge. The update bit reads back 1 while the transfer is in flight and clears itself afterwards. Software polls that bit to find out when the new setting has taken hold.

Each shadow register has its own change flag in the command register, and all flags drop when an update lands. The command register also carries a root-enable control, which acts at once and is not shadowed. It also carries a read-only status bit that reads 1 whenever the root clock is stopped. The mux, the pre-divider and the M/N counter themselves sit outside this block and consume only the active outputs.

Top module: `crc_root_cfg`

## Requirements
- R1: After reset every register reads 0 except command bit 31. All active outputs and `rootEnable` are 0.
- R2: Registers are selected by `addr[4:2]`: command at 0x00, configuration at 0x04, M at 0x08, N at 0x0C and D at 0x10. `addr[1:0]` is ignored. Any other offset reads 0, and writes to it change nothing.
- R3: The configuration register keeps the pre-divider in bits [PDIV_W-1:0], the source code in bits [10:8] and the mode in bits [13:12]. All its other bits read 0. M, N and D keep their low MND_W bits, and their upper bits read 0.
- R4: A write to a shadow register leaves all active outputs unchanged until an update is applied.
- R5: A command write with bit 0 set makes bit 0 read 1 for exactly UPD_LAT cycles. On the clock edge that ends this window, every active output takes the shadow value and bit 0 returns to 0.
- R6: An update request made while one is in flight is ignored and does not restart the window. A command write with bit 0 clear does not cancel a request that is in flight.
- R7: Writing the configuration register sets command bit 4. Writing N sets bit 5, writing M sets bit 6 and writing D sets bit 7. All four bits clear when an update is applied. Writes to bits 7:4 have no effect.
- R8: Command bit 1 can be read and written, and it drives `rootEnable` from the next edge with no shadow stage.
- R9: Command bit 31 reads the inverse of `rootClkRunning`, and writes to it have no effect.
- R10: A shadow write on the same edge that applies an update goes to the shadow register only. The active copy takes the value the shadow held before that write, and the written register's change flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | ADDR_W | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| rootClkRunning | input | 1 | High while the root clock output toggles |
| rootEnable | output | 1 | Root enable control for the clock gate |
| actSrcSel | output | 3 | Active source-select code |
| actMode | output | 2 | Active counter mode (2 = dual-edge M/N) |
| actPreDiv | output | PDIV_W | Active pre-divider value |
| actM | output | MND_W | Active M value |
| actN | output | MND_W | Active N value |
| actD | output | MND_W | Active D value |

## Verification
The hardest case to reach is a shadow write that lands on exactly the edge where an update is applied. Both outcomes can look right from the ports. The flag must stay set, and the active copy must take the older shadow value. The directed part of the bench issues a request, idles for UPD_LAT-1 cycles and then writes M, so that the write meets the apply edge. Repeated requests inside the window are aimed in the same way. The random phase adds many more of these coincidences, because command writes with bit 0 set are weighted heavily among the stimulus.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int WORD_CMD = 0;
  localparam int WORD_CFG = 1;
  localparam int WORD_M   = 2;
  localparam int WORD_N   = 3;
  localparam int WORD_D   = 4;

  typedef struct packed {
    logic wrCmd;
    logic wrCfg;
    logic wrM;
    logic wrN;
    logic wrD;
    logic apply;
  } strobe_t;
endpackage

// File: rtl/crc_ctrl.sv
module crc_ctrl import crc_pkg::*; #(
  parameter int ADDR_W  = 5,
  parameter int UPD_LAT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              reqBit,
  output strobe_t           strb,
  output logic              pending,
  output logic [3:0]        dirty
);
  localparam int CNT_W = (UPD_LAT > 2) ? $clog2(UPD_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(UPD_LAT - 1);

  logic [CNT_W-1:0] cnt;
  logic [ADDR_W-3:0] word;
  logic start;

  assign word = addr[ADDR_W-1:2];

  always_comb begin
    strb.wrCmd = wrEn && (word == (ADDR_W-2)'(WORD_CMD));
    strb.wrCfg = wrEn && (word == (ADDR_W-2)'(WORD_CFG));
    strb.wrM   = wrEn && (word == (ADDR_W-2)'(WORD_M));
    strb.wrN   = wrEn && (word == (ADDR_W-2)'(WORD_N));
    strb.wrD   = wrEn && (word == (ADDR_W-2)'(WORD_D));
    strb.apply = pending && (cnt == '0);
  end

  assign start = strb.wrCmd && reqBit && (!pending || strb.apply);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      pending <= 1'b1;
      cnt     <= CNT_INIT;
    end else if (strb.apply) begin
      pending <= 1'b0;
    end else if (pending) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) dirty <= '0;
    else dirty <= (strb.apply ? 4'b0 : dirty) | {strb.wrD, strb.wrM, strb.wrN, strb.wrCfg};
  end

  // R6
  upd_norestart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending && cnt != '0) |=> (pending && cnt == $past(cnt) - 1'b1));

  // R5
  upd_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.apply && !start) |=> !pending);

  // R7
  dirty_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.apply && !(strb.wrCfg || strb.wrM || strb.wrN || strb.wrD)) |=> (dirty == 4'b0));

  // R7
  dirty_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCfg |=> dirty[0]);
endmodule

// File: rtl/crc_regs.sv
module crc_regs import crc_pkg::*; #(
  parameter int ADDR_W = 5,
  parameter int PDIV_W = 5,
  parameter int MND_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  input  logic              pending,
  input  logic [3:0]        dirty,
  input  logic              rootClkRunning,
  output logic [31:0]       rdData,
  output logic              rootEnable,
  output logic [2:0]        actSrcSel,
  output logic [1:0]        actMode,
  output logic [PDIV_W-1:0] actPreDiv,
  output logic [MND_W-1:0]  actMnd [3]
);
  logic [2:0]        shSrc;
  logic [1:0]        shMode;
  logic [PDIV_W-1:0] shPreDiv;
  logic [MND_W-1:0]  shMnd [3];
  logic [2:0]        wrMnd;
  logic [ADDR_W-3:0] word;

  assign wrMnd = {strb.wrD, strb.wrN, strb.wrM};
  assign word  = addr[ADDR_W-1:2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shSrc <= '0; shMode <= '0; shPreDiv <= '0;
      actSrcSel <= '0; actMode <= '0; actPreDiv <= '0;
      rootEnable <= 1'b0;
    end else begin
      if (strb.apply) begin
        actSrcSel <= shSrc;
        actMode   <= shMode;
        actPreDiv <= shPreDiv;
      end
      if (strb.wrCfg) begin
        shPreDiv <= wrData[PDIV_W-1:0];
        shSrc    <= wrData[10:8];
        shMode   <= wrData[13:12];
      end
      if (strb.wrCmd) rootEnable <= wrData[1];
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_mnd
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shMnd[g]  <= '0;
        actMnd[g] <= '0;
      end else begin
        if (strb.apply) actMnd[g] <= shMnd[g];
        if (wrMnd[g])   shMnd[g]  <= wrData[MND_W-1:0];
      end
    end

    // R5
    act_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.apply |=> (actMnd[g] == $past(shMnd[g])));

    // R4
    act_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strb.apply |=> $stable(actMnd[g]));
  end

  always_comb begin
    rdData = '0;
    case (word)
      (ADDR_W-2)'(WORD_CMD): begin
        rdData[0]   = pending;
        rdData[1]   = rootEnable;
        rdData[7:4] = dirty;
        rdData[31]  = !rootClkRunning;
      end
      (ADDR_W-2)'(WORD_CFG): begin
        rdData[PDIV_W-1:0] = shPreDiv;
        rdData[10:8]       = shSrc;
        rdData[13:12]      = shMode;
      end
      (ADDR_W-2)'(WORD_M): rdData[MND_W-1:0] = shMnd[0];
      (ADDR_W-2)'(WORD_N): rdData[MND_W-1:0] = shMnd[1];
      (ADDR_W-2)'(WORD_D): rdData[MND_W-1:0] = shMnd[2];
      default: rdData = '0;
    endcase
  end

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.apply |=> ($stable(actSrcSel) && $stable(actMode) && $stable(actPreDiv)));

  // R10
  cfg_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.apply |=> (actSrcSel == $past(shSrc) && actMode == $past(shMode)));
endmodule

// File: rtl/crc_root_cfg.sv
module crc_root_cfg import crc_pkg::*; #(
  parameter int ADDR_W  = 5,
  parameter int PDIV_W  = 5,
  parameter int MND_W   = 8,
  parameter int UPD_LAT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              rootClkRunning,
  output logic              rootEnable,
  output logic [2:0]        actSrcSel,
  output logic [1:0]        actMode,
  output logic [PDIV_W-1:0] actPreDiv,
  output logic [MND_W-1:0]  actM,
  output logic [MND_W-1:0]  actN,
  output logic [MND_W-1:0]  actD
);
  strobe_t          strb;
  logic             pending;
  logic [3:0]       dirty;
  logic [MND_W-1:0] actMnd [3];

  crc_ctrl #(.ADDR_W(ADDR_W), .UPD_LAT(UPD_LAT)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .reqBit(wrData[0]),
    .strb(strb), .pending(pending), .dirty(dirty)
  );

  crc_regs #(.ADDR_W(ADDR_W), .PDIV_W(PDIV_W), .MND_W(MND_W)) regs_i (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wrData(wrData),
    .pending(pending), .dirty(dirty), .rootClkRunning(rootClkRunning),
    .rdData(rdData), .rootEnable(rootEnable), .actSrcSel(actSrcSel),
    .actMode(actMode), .actPreDiv(actPreDiv), .actMnd(actMnd)
  );

  assign actM = actMnd[0];
  assign actN = actMnd[1];
  assign actD = actMnd[2];
endmodule

// File: tb/crc_root_cfg_tb.sv
`timescale 1ns/1ps
module crc_root_cfg_tb_top;
  localparam int ADDR_W = 5, PDIV_W = 5, MND_W = 8, UPD_LAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wrData = '0;
  logic rootClkRunning = 1'b0;
  logic [31:0] rdData;
  logic rootEnable;
  logic [2:0] actSrcSel;
  logic [1:0] actMode;
  logic [PDIV_W-1:0] actPreDiv;
  logic [MND_W-1:0] actM, actN, actD;

  int checks = 0;
  int fails = 0;

  // bench model
  logic [31:0] mSh [5];
  logic [31:0] mAct [5];
  logic [3:0]  mDirty = '0;
  logic        mPend = 1'b0;
  int          mCnt = 0;
  logic        mRootEn = 1'b0;

  always #4 clk = ~clk;

  crc_root_cfg #(.ADDR_W(ADDR_W), .PDIV_W(PDIV_W), .MND_W(MND_W), .UPD_LAT(UPD_LAT)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .rootClkRunning(rootClkRunning), .rootEnable(rootEnable), .actSrcSel(actSrcSel),
    .actMode(actMode), .actPreDiv(actPreDiv), .actM(actM), .actN(actN), .actD(actD)
  );

  function automatic logic [31:0] maskOf(int w);
    case (w)
      1: return 32'h0000_3700 | ((32'd1 << PDIV_W) - 1);
      2, 3, 4: return (32'd1 << MND_W) - 1;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] expRead(int w);
    if (w == 0) return {!rootClkRunning, 23'd0, mDirty, 2'd0, mRootEn, mPend};
    if (w >= 1 && w <= 4) return mSh[w];
    return 32'd0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkOuts();
    logic [31:0] c;
    c = mAct[1];
    check("R4 actSrcSel", 32'(actSrcSel), 32'(c[10:8]));
    check("R4 actMode", 32'(actMode), 32'(c[13:12]));
    check("R4 actPreDiv", 32'(actPreDiv), 32'(c[PDIV_W-1:0]));
    check("R10 actM", 32'(actM), mAct[2]);
    check("R10 actN", 32'(actN), mAct[3]);
    check("R10 actD", 32'(actD), mAct[4]);
    check("R8 rootEnable", 32'(rootEnable), 32'(mRootEn));
  endtask

  // one bus cycle; read data checked before the edge, model advanced after it
  task automatic busOp(logic wr, logic [ADDR_W-1:0] a, logic [31:0] d, string tag);
    int w;
    logic applyNow;
    @(negedge clk);
    wrEn = wr; addr = a; wrData = d;
    #1;
    w = int'(a[ADDR_W-1:2]);
    if (!wr) check(tag, rdData, expRead(w));
    checkOuts();
    @(posedge clk);
    applyNow = mPend && (mCnt == 0);
    if (applyNow) begin
      for (int i = 1; i < 5; i++) mAct[i] = mSh[i];
      mPend = 1'b0; mDirty = '0;
    end else if (mPend) mCnt--;
    if (wr) begin
      case (w)
        0: begin
          mRootEn = d[1];
          if (d[0] && !mPend) begin mPend = 1'b1; mCnt = UPD_LAT - 1; end
        end
        1: begin mSh[1] = d & maskOf(1); mDirty[0] = 1'b1; end
        2: begin mSh[2] = d & maskOf(2); mDirty[2] = 1'b1; end
        3: begin mSh[3] = d & maskOf(3); mDirty[1] = 1'b1; end
        4: begin mSh[4] = d & maskOf(4); mDirty[3] = 1'b1; end
        default: ;
      endcase
    end
  endtask

  task automatic readAll(string tag);
    for (int w = 0; w < 8; w++) busOp(1'b0, ADDR_W'(w * 4), 32'd0, tag);
  endtask

  initial begin
    #(8ns * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 5; i++) begin mSh[i] = '0; mAct[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state (bit 31 = 1 since the clock is stopped)
    readAll("R1");
    rootClkRunning = 1'b1;
    busOp(1'b0, 5'h00, 0, "R9 running");

    // R3 field masks, R4 shadow only, R7 dirty set
    busOp(1'b1, 5'h04, 32'hFFFF_FFFF, "R3");
    busOp(1'b1, 5'h09, 32'hFFFF_FFA5, "R2");
    busOp(1'b1, 5'h0C, 32'h0000_013C, "R3");
    busOp(1'b1, 5'h10, 32'h0000_0077, "R3");
    readAll("R3");
    // R2 unmapped writes ignored
    busOp(1'b1, 5'h14, 32'hFFFF_FFFF, "R2");
    busOp(1'b1, 5'h1C, 32'hFFFF_FFFF, "R2");
    readAll("R2");

    // R5 update window, polled every cycle; R8 root enable set
    busOp(1'b1, 5'h00, 32'h0000_0003, "R5");
    repeat (UPD_LAT + 1) busOp(1'b0, 5'h00, 0, "R5 poll");
    readAll("R7 cleared");

    // R6 re-request and bit0=0 write during window
    busOp(1'b1, 5'h08, 32'h11, "R6");
    busOp(1'b1, 5'h00, 32'h1, "R6");
    busOp(1'b1, 5'h00, 32'h1, "R6");
    busOp(1'b1, 5'h00, 32'h0, "R6 R8");
    busOp(1'b0, 5'h00, 0, "R6 poll");
    busOp(1'b0, 5'h00, 0, "R6 poll");

    // R10 shadow write on the apply edge
    busOp(1'b1, 5'h00, 32'h1, "R10");
    for (int i = 0; i < UPD_LAT - 1; i++) busOp(1'b0, 5'h00, 0, "R10 poll");
    busOp(1'b1, 5'h08, 32'h5A, "R10");
    busOp(1'b0, 5'h00, 0, "R7 flag kept");
    busOp(1'b0, 5'h08, 0, "R10 shadow");

    // R7 writes to dirty bits ignored; R9 bit 31 write ignored
    rootClkRunning = 1'b0;
    busOp(1'b1, 5'h00, 32'h8000_00F0, "R7");
    busOp(1'b0, 5'h00, 0, "R9 stopped");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic wr;
      logic [ADDR_W-1:0] a;
      logic [31:0] d;
      rootClkRunning = 1'($urandom % 2);
      wr = ($urandom % 3) != 0;
      a = ADDR_W'((($urandom % 8) * 4) + ($urandom % 4));
      if (($urandom % 3) == 0) a = ADDR_W'($urandom % 4);
      d = $urandom;
      case (int'(a[ADDR_W-1:2]))
        0: busOp(wr, a, d, wr ? "R5" : "R7 rand cmd");
        1: busOp(wr, a, d, "R3 rand cfg");
        2, 3, 4: busOp(wr, a, d, "R4 rand mnd");
        default: busOp(wr, a, d, "R2 rand unmapped");
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule